// File: doc/BRIEF.md
# Masked Vector Register Writeback Unit

This block owns a small file of 512-bit vector registers and commits one result vector per clock into a chosen entry. The result is viewed as eight 64-bit lanes. Each request names an active length (128, 256 or 512 bits), an 8-bit lane mask with an enable, a mode bit that picks between keeping or zeroing the lanes the mask leaves out, and an encoding class. The class decides whether masking applies and whether the register bits above the active length are cleared or kept.

A 4-bit reserved specifier field travels with each request and must be all ones. A request with a bad specifier, an undefined class or a length that its class does not allow is refused. The block raises a one-cycle illegal-instruction flag and leaves the register file untouched. A combinational read port returns any entry, and reads the value from before the clock edge when it points at the entry being written.

Top module: `vec_wb_unit`

## Requirements
- R1: Lane j occupies bits 64j+63:64j. The length code `wr_vlen` is 0 for 128 bits (2 lanes), 1 for 256 bits (4 lanes) and 2 for 512 bits (8 lanes).
- R2: In the masked class (`wr_class`=2), an active lane takes the source lane when its mask bit is set or when `wr_mask_en` is low.
- R3: In the masked class with `wr_zero` low, an active lane whose mask bit is clear keeps its old contents.
- R4: In the masked class with `wr_zero` high, an active lane whose mask bit is clear is written with zeros.
- R5: Mask bits at positions equal to or above the active lane count have no effect.
- R6: For the plain class (`wr_class`=1) and the masked class, every bit from the active length up to bit 511 is cleared by the write.
- R7: The legacy class (`wr_class`=0) always writes 128 bits. It replaces bits 127:0, keeps bits 511:128, and ignores `wr_vlen` and the mask.
- R8: The plain class ignores the mask and the mode bit and writes every active lane from the source.
- R9: A request with `wr_rsvd` other than 4'b1111 raises `fault` and does not modify any entry.
- R10: Class 3, length code 3, and the plain class with length code 2 are illegal. They raise `fault` and do not modify any entry.
- R11: `fault` is high only in the cycle of a valid refused request. An accepted write takes effect on the next rising clock edge, and nothing changes while `wr_valid` is low.
- R12: Reset clears every entry to zero. A read of the entry being written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | 3 | Destination entry |
| wr_data | input | 512 | Source vector |
| wr_vlen | input | 2 | Active length code |
| wr_mask | input | 8 | Per-lane mask |
| wr_mask_en | input | 1 | Mask applies (masked class only) |
| wr_zero | input | 1 | 1: zero unselected lanes, 0: keep them |
| wr_class | input | 2 | Encoding class |
| wr_rsvd | input | 4 | Reserved specifier, must be 4'b1111 |
| fault | output | 1 | Illegal-instruction flag for the current request |
| rd_addr | input | 3 | Read entry |
| rd_data | output | 512 | Read data, combinational |

## Verification
A write and a read of the same entry can occur in the same cycle. The bench points the read port at the destination while the write is presented and compares the output before the edge with the model's old contents. It then reads the entry after the edge and expects the merged value. A lane-mask merge and a refused request also meet when a fault arrives with a mask that would have changed the entry. The bench judges this by reading back the entry unchanged and by seeing `fault` high in that same cycle.

// File: rtl/vwb_pkg.sv
// Shared encodings for the writeback unit.
package vwb_pkg;
    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_UNDEF  = 2'd3
    } wb_class_e;

    localparam logic [3:0] RSVD_OK = 4'b1111;
endpackage

// File: rtl/vwb_decode.sv
// Request legality and control decode.
// Takes class, length code and reserved field. Produces the active lane
// count, whether the mask applies, whether upper bits are kept, and an
// illegal flag. Assumes the minimum length is MIN_LANES lanes, doubling per code step.
module vwb_decode #(
    parameter int MAX_LANES = 8,
    parameter int MIN_LANES = 2,
    localparam int CNT_W    = $clog2(MAX_LANES) + 1
) (
    input  logic [1:0]       cls,
    input  logic [1:0]       vlen,
    input  logic [3:0]       rsvd,
    output logic             illegal,
    output logic [CNT_W-1:0] lanes,
    output logic             use_mask,
    output logic             keep_upper
);
    import vwb_pkg::*;

    wb_class_e cls_e;
    assign cls_e = wb_class_e'(cls);

    // Classify the request and derive lane count and upper-bit policy.
    always_comb begin
        illegal    = (rsvd != RSVD_OK);
        lanes      = CNT_W'(MIN_LANES);
        use_mask   = 1'b0;
        keep_upper = 1'b0;
        case (cls_e)
            CLS_LEGACY: keep_upper = 1'b1;
            CLS_PLAIN: begin
                if (vlen >= 2'd2) illegal = 1'b1;
                lanes = CNT_W'(MIN_LANES) << vlen;
            end
            CLS_MASKED: begin
                if (vlen == 2'd3) illegal = 1'b1;
                lanes    = CNT_W'(MIN_LANES) << vlen;
                use_mask = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/vwb_lane_merge.sv
// Per-lane merge of source and old register contents.
// Lanes below the active count take the source, the old value or zero,
// depending on mask and mode. Lanes above it are kept or cleared by keep_upper.
module vwb_lane_merge #(
    parameter int LANE_W    = 64,
    parameter int MAX_LANES = 8,
    localparam int VEC_W    = LANE_W * MAX_LANES,
    localparam int CNT_W    = $clog2(MAX_LANES) + 1
) (
    input  logic [VEC_W-1:0]     src,
    input  logic [VEC_W-1:0]     old,
    input  logic [CNT_W-1:0]     lanes,
    input  logic [MAX_LANES-1:0] mask,
    input  logic                 mask_en,
    input  logic                 use_mask,
    input  logic                 zero_mode,
    input  logic                 keep_upper,
    output logic [VEC_W-1:0]     merged
);
    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic in_len;
        logic sel;
        assign in_len = (CNT_W'(j) < lanes);
        assign sel    = !use_mask || !mask_en || mask[j];

        // Choose this lane's new contents.
        always_comb begin
            if (in_len) begin
                if (sel)            merged[j*LANE_W +: LANE_W] = src[j*LANE_W +: LANE_W];
                else if (zero_mode) merged[j*LANE_W +: LANE_W] = '0;
                else                merged[j*LANE_W +: LANE_W] = old[j*LANE_W +: LANE_W];
            end else if (keep_upper) begin
                merged[j*LANE_W +: LANE_W] = old[j*LANE_W +: LANE_W];
            end else begin
                merged[j*LANE_W +: LANE_W] = '0;
            end
        end
    end
endmodule

// File: rtl/vwb_regfile.sv
// Vector register storage with one write port and combinational reads.
// Also gives the old contents of the write target to the merge logic and
// the whole array to the checker. Reset clears all entries.
module vwb_regfile #(
    parameter int VEC_W    = 512,
    parameter int NUM_REGS = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [VEC_W-1:0]                 wdata,
    input  logic [ADDR_W-1:0]                raddr,
    output logic [VEC_W-1:0]                 rdata,
    output logic [VEC_W-1:0]                 old_data,
    output logic [NUM_REGS-1:0][VEC_W-1:0]   all_q
);
    logic [NUM_REGS-1:0][VEC_W-1:0] mem;

    // Clear on reset, otherwise commit the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)  mem        <= '0;
        else if (we) mem[waddr] <= wdata;
    end

    assign rdata    = mem[raddr];
    assign old_data = mem[waddr];
    assign all_q    = mem;
endmodule

// File: rtl/vec_wb_unit.sv
// Masked vector register writeback unit, top level.
// Decodes the request, merges the source into the old entry and commits it
// when legal. A refused valid request pulses fault in the same cycle.
module vec_wb_unit #(
    parameter int LANE_W    = 64,
    parameter int MAX_LANES = 8,
    parameter int MIN_LANES = 2,
    parameter int NUM_REGS  = 8,
    localparam int VEC_W    = LANE_W * MAX_LANES,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int CNT_W    = $clog2(MAX_LANES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [VEC_W-1:0]     wr_data,
    input  logic [1:0]           wr_vlen,
    input  logic [MAX_LANES-1:0] wr_mask,
    input  logic                 wr_mask_en,
    input  logic                 wr_zero,
    input  logic [1:0]           wr_class,
    input  logic [3:0]           wr_rsvd,
    output logic                 fault,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [VEC_W-1:0]     rd_data
);
    logic                           illegal;
    logic [CNT_W-1:0]               lanes;
    logic                           use_mask;
    logic                           keep_upper;
    logic [VEC_W-1:0]               old_data;
    logic [VEC_W-1:0]               merged;
    logic                           commit;
    logic [NUM_REGS-1:0][VEC_W-1:0] rf_all;

    vwb_decode #(.MAX_LANES(MAX_LANES), .MIN_LANES(MIN_LANES)) u_dec (
        .cls(wr_class), .vlen(wr_vlen), .rsvd(wr_rsvd),
        .illegal(illegal), .lanes(lanes), .use_mask(use_mask),
        .keep_upper(keep_upper)
    );

    vwb_lane_merge #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_merge (
        .src(wr_data), .old(old_data), .lanes(lanes), .mask(wr_mask),
        .mask_en(wr_mask_en), .use_mask(use_mask), .zero_mode(wr_zero),
        .keep_upper(keep_upper), .merged(merged)
    );

    assign commit = wr_valid && !illegal;
    assign fault  = wr_valid && illegal;

    vwb_regfile #(.VEC_W(VEC_W), .NUM_REGS(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_addr),
        .wdata(merged), .raddr(rd_addr), .rdata(rd_data),
        .old_data(old_data), .all_q(rf_all)
    );
endmodule

// File: rtl/vec_wb_unit_chk.sv
// Property checker for vec_wb_unit, attached by bind below.
// Watches the request ports, the fault flag and the register array.
module vec_wb_unit_chk #(
    parameter int VEC_W    = 512,
    parameter int NUM_REGS = 8,
    parameter int LEG_W    = 128,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_valid,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [1:0]                     wr_vlen,
    input logic [1:0]                     wr_class,
    input logic [3:0]                     wr_rsvd,
    input logic                           fault,
    input logic [NUM_REGS-1:0][VEC_W-1:0] rf_all
);
    logic [VEC_W-1:0]  tgt_now;
    logic [VEC_W-1:0]  tgt_prev;
    logic [ADDR_W-1:0] addr_prev;
    logic [VEC_W-1:0]  written;

    assign tgt_now = rf_all[wr_addr];
    assign written = rf_all[addr_prev];

    // Remember the target entry and address of the previous cycle.
    always_ff @(posedge clk) begin
        tgt_prev  <= tgt_now;
        addr_prev <= wr_addr;
    end

    // R9
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_rsvd != 4'b1111) |-> fault);

    // R11
    fault_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> wr_valid);

    // R9
    fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (rf_all == $past(rf_all)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (rf_all == $past(rf_all)));

    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !fault && wr_class == 2'd0)
        |=> (written[VEC_W-1:LEG_W] == tgt_prev[VEC_W-1:LEG_W]));

    // R6
    short_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !fault && wr_class != 2'd0 && wr_vlen == 2'd0)
        |=> (written[VEC_W-1:LEG_W] == '0));
endmodule

bind vec_wb_unit vec_wb_unit_chk #(.VEC_W(VEC_W), .NUM_REGS(NUM_REGS), .LEG_W(LANE_W*MIN_LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_vlen(wr_vlen), .wr_class(wr_class), .wr_rsvd(wr_rsvd),
    .fault(fault), .rf_all(rf_all)
);

// File: tb/sim_vec_wb_unit.sv
module sim_vec_wb_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [511:0] wr_data = '0;
    logic [1:0]   wr_vlen = '0;
    logic [7:0]   wr_mask = '0;
    logic         wr_mask_en = 1'b0;
    logic         wr_zero = 1'b0;
    logic [1:0]   wr_class = '0;
    logic [3:0]   wr_rsvd = 4'hF;
    logic         fault;
    logic [2:0]   rd_addr = '0;
    logic [511:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [511:0] model [8];
    logic [511:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    vec_wb_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_vlen(wr_vlen), .wr_mask(wr_mask),
        .wr_mask_en(wr_mask_en), .wr_zero(wr_zero), .wr_class(wr_class),
        .wr_rsvd(wr_rsvd), .fault(fault), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [511:0] pat(input int seed);
        logic [511:0] v;
        for (int j = 0; j < 8; j++) v[j*64 +: 64] = {32'(seed), 32'(j + 1)};
        return v;
    endfunction

    // Expected entry from the requirements (R1..R10).
    function automatic logic [511:0] predict(input logic [511:0] old, input logic [511:0] src,
            input logic [1:0] vl, input logic [7:0] m, input logic men, input logic z,
            input logic [1:0] cls, input logic [3:0] rs, output logic flt);
        logic [511:0] r;
        int n;
        flt = (rs != 4'hF) || (cls == 2'd3) || (cls != 2'd0 && vl == 2'd3) ||
              (cls == 2'd1 && vl == 2'd2);
        if (flt) return old;
        n = (cls == 2'd0) ? 2 : (2 << vl);
        for (int j = 0; j < 8; j++) begin
            if (j < n) begin
                if (cls != 2'd2 || !men || m[j]) r[j*64 +: 64] = src[j*64 +: 64];
                else if (z)                      r[j*64 +: 64] = '0;
                else                             r[j*64 +: 64] = old[j*64 +: 64];
            end else begin
                r[j*64 +: 64] = (cls == 2'd0) ? old[j*64 +: 64] : '0;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one request, check fault and same-cycle read, queue expected entry.
    task automatic drive(input string req, input logic [2:0] a, input logic [511:0] d,
            input logic [1:0] vl, input logic [7:0] m, input logic men, input logic z,
            input logic [1:0] cls, input logic [3:0] rs);
        logic [511:0] nv;
        logic flt;
        nv = predict(model[a], d, vl, m, men, z, cls, rs, flt);
        @(negedge clk);
        #2;
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_vlen = vl; wr_mask = m;
        wr_mask_en = men; wr_zero = z; wr_class = cls; wr_rsvd = rs; rd_addr = a;
        #1;
        check(fault == flt, {req, " fault flag"}, 512'(fault), 512'(flt));
        // R12 same-cycle read returns the old contents
        check(rd_data == model[a], "R12 same-cycle read", rd_data, model[a]);
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        wr_rsvd = 4'h0;
        model[a] = nv;
        rd_addr = a;
        exp_q.push_back(nv);
        tag_q.push_back(req);
    endtask

    // Monitor: compare read data against the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [511:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
        end
    end

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state of every entry
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_addr = 3'(i);
            #1 check(rd_data == '0, "R12 reset zero", rd_data, '0);
        end
        // R1 R2 full-length masked write, mask disabled
        drive("R1 R2 full write", 3'd1, pat(11), 2'd2, 8'h00, 1'b0, 1'b0, 2'd2, 4'hF);
        // R3 merge under mask 8'hA5
        drive("R3 merge keep", 3'd1, pat(22), 2'd2, 8'hA5, 1'b1, 1'b0, 2'd2, 4'hF);
        // R4 zero mode under mask 8'h3C
        drive("R4 zero lanes", 3'd1, pat(33), 2'd2, 8'h3C, 1'b1, 1'b1, 2'd2, 4'hF);
        // R5 R6 256-bit, upper mask bits set but ignored, upper cleared
        drive("R1 full setup", 3'd2, pat(44), 2'd2, 8'h00, 1'b0, 1'b0, 2'd2, 4'hF);
        drive("R5 R6 length 256", 3'd2, pat(55), 2'd1, 8'hF2, 1'b1, 1'b0, 2'd2, 4'hF);
        // R4 R6 128-bit zero mode
        drive("R4 R6 length 128", 3'd1, pat(66), 2'd0, 8'h01, 1'b1, 1'b1, 2'd2, 4'hF);
        // R8 plain class ignores mask and mode
        drive("R1 full setup", 3'd3, pat(77), 2'd2, 8'h00, 1'b0, 1'b0, 2'd2, 4'hF);
        drive("R8 plain 256", 3'd3, pat(88), 2'd1, 8'h00, 1'b1, 1'b1, 2'd1, 4'hF);
        // R7 legacy keeps upper bits, vlen and mask ignored
        drive("R1 full setup", 3'd4, pat(99), 2'd2, 8'h00, 1'b0, 1'b0, 2'd2, 4'hF);
        drive("R7 legacy", 3'd4, pat(123), 2'd2, 8'h00, 1'b1, 1'b1, 2'd0, 4'hF);
        // R9 bad reserved field
        drive("R9 reserved fault", 3'd4, pat(7), 2'd2, 8'hFF, 1'b1, 1'b0, 2'd2, 4'hE);
        // R10 undefined class, bad length code, plain at 512
        drive("R10 class 3", 3'd1, pat(8), 2'd2, 8'hFF, 1'b0, 1'b0, 2'd3, 4'hF);
        drive("R10 length code 3", 3'd2, pat(9), 2'd3, 8'hFF, 1'b0, 1'b0, 2'd2, 4'hF);
        drive("R10 plain 512", 3'd3, pat(10), 2'd2, 8'hFF, 1'b0, 1'b0, 2'd1, 4'hF);
        // R11 no request: bad field while idle gives no fault and no change
        @(negedge clk);
        #2 wr_valid = 1'b0; wr_rsvd = 4'h0; wr_class = 2'd3; rd_addr = 3'd4;
        #1 check(fault == 1'b0, "R11 idle no fault", 512'(fault), '0);
        @(negedge clk);
        #1 check(rd_data == model[4], "R11 idle no change", rd_data, model[4]);
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule